// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block resolves an address translation that missed in the translation buffer. It holds an inverted page table: one row for each physical frame, so the row index is the frame number. Each row stores the owning virtual page number, the owning process identifier, a physical page number, and a link to the next row that shares its hash bucket.

A request carries a virtual address and a process identifier. The walker folds the page-number part of the address and the process identifier into a small hash. The hash selects an entry of the anchor table, and that entry names the first candidate row. The walker then follows the chain of rows. At every row it compares the stored page number and process identifier with the request, so that a hash collision is not taken for a hit. It stops at the first match or at the end of the chain. A walk that meets an empty anchor entry, runs off the end of its chain, or visits as many rows as there are frames ends in a page fault.

Both tables are filled through plain write ports while the walker is idle. The response is a single-cycle pulse that carries either a fault flag or the frame, the stored physical page number and the full physical address, ready to be installed in the translation buffer.

Top module: `ipt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` is 0, and every anchor entry reads as empty.
- R2: `req_vaddr[11:0]` is the in-page offset and `req_vaddr[31:12]` is the virtual page number. The offset never changes the lookup, and on a hit `resp_paddr` equals `{resp_ppn, offset}`.
- R3: The anchor index is the XOR of the consecutive 6-bit slices, starting at bit 0, of the 28-bit key `{pid[7:0], vpn[19:0]}`.
- R4: If the selected anchor entry is empty, `resp_valid` pulses with `resp_fault`=1 exactly 2 cycles after the cycle in which the request is accepted.
- R5: If the first row of the chain matches in both page number and process identifier, `resp_valid` pulses with `resp_fault`=0 four cycles after acceptance. `resp_frame` is that row's index and `resp_ppn` is its stored physical page number.
- R6: A row whose page number or process identifier differs from the request is skipped and its link is followed. A match at the k-th visited row responds 2+2k cycles after acceptance.
- R7: When a visited row does not match and its link is marked invalid, the walk ends with a fault 2+2k cycles after acceptance, where k is the number of rows visited.
- R8: A chain that visits 64 rows without a match ends in a fault 130 cycles after acceptance, even if the links form a loop.
- R9: `req_ready` is high only while the walker is idle, and a `req_valid` raised while it is busy is ignored. `resp_valid` lasts exactly one cycle, and `req_ready` rises in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe, taken when `req_ready` is high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_pid | input | 8 | Process identifier of the request |
| req_ready | output | 1 | Walker idle and able to take a request |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_fault | output | 1 | Result is a page fault |
| resp_frame | output | 6 | Index of the matching row (frame number) |
| resp_ppn | output | 6 | Physical page number stored in the matching row |
| resp_paddr | output | 18 | Stored physical page number joined with the request offset |
| anc_we | input | 1 | Anchor table write strobe |
| anc_waddr | input | 6 | Anchor entry to write |
| anc_wvalid | input | 1 | Written entry is occupied (0 empties it) |
| anc_wrow | input | 6 | First row of the bucket's chain |
| row_we | input | 1 | Row table write strobe |
| row_waddr | input | 6 | Row (frame) to write |
| row_wvpn | input | 20 | Virtual page number owning the frame |
| row_wpid | input | 8 | Process identifier owning the frame |
| row_wppn | input | 6 | Physical page number stored in the row |
| row_wlink_valid | input | 1 | The row's link is valid |
| row_wlink | input | 6 | Next row in the collision chain |

## Verification
The bench builds the walker with its default sizes: 64 frames, 64 anchor entries, a 20-bit page number, an 8-bit process identifier and a 12-bit offset. With 64 frames, the step bound that ends a looping chain is reached within 130 cycles, so the looping case runs in full next to the short chains. The small hash leaves many keys that collide, so the bench can choose three keys that share one bucket, two of them with the same page number and different process identifiers. It then checks hits at each position in the chain, a miss at the end of the chain, and a request raised while a long walk is in progress.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  typedef enum logic [2:0] {
    WS_IDLE    = 3'd0,
    WS_ANCHOR  = 3'd1,
    WS_ROW     = 3'd2,
    WS_COMPARE = 3'd3,
    WS_DONE    = 3'd4,
    WS_FAULT   = 3'd5
  } walk_state_e;

endpackage

// File: rtl/ipt_sram.sv
module ipt_sram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/ipt_anchor_table.sv
module ipt_anchor_table #(
  parameter int HASH_W = 6,
  parameter int IDX_W  = 6,
  localparam int DEPTH = 1 << HASH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [HASH_W-1:0] waddr,
  input  logic              wvalid,
  input  logic [IDX_W-1:0]  widx,
  input  logic [HASH_W-1:0] raddr,
  output logic              rvalid,
  output logic [IDX_W-1:0]  ridx
);

  // Occupancy flags live in flops so that reset empties every bucket.
  logic [DEPTH-1:0] occ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (we) occ_q[waddr] <= wvalid;
      rvalid <= occ_q[raddr];
    end
  end

  ipt_sram #(.WIDTH(IDX_W), .DEPTH(DEPTH)) u_head (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (widx),
    .raddr (raddr),
    .rdata (ridx)
  );

endmodule

// File: rtl/ipt_walk_fsm.sv
module ipt_walk_fsm
  import ipt_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PID_W  = 8,
  parameter int PPN_W  = 6,
  parameter int FRAMES = 64,
  parameter int HASH_W = 6,
  localparam int FRAME_W = $clog2(FRAMES),
  localparam int STEP_W  = $clog2(FRAMES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [PID_W-1:0]   req_pid,
  output logic               req_ready,
  output logic [HASH_W-1:0]  anc_raddr,
  input  logic               anc_rvalid,
  input  logic [FRAME_W-1:0] anc_ridx,
  output logic [FRAME_W-1:0] row_raddr,
  input  logic [VPN_W-1:0]   row_rvpn,
  input  logic [PID_W-1:0]   row_rpid,
  input  logic [PPN_W-1:0]   row_rppn,
  input  logic               row_rlink_valid,
  input  logic [FRAME_W-1:0] row_rlink,
  output logic               resp_valid,
  output logic               resp_fault,
  output logic [FRAME_W-1:0] resp_frame,
  output logic [PPN_W-1:0]   resp_ppn,
  output logic               ev_accept,
  output logic               ev_anchor_miss,
  output logic               ev_row_hit,
  output logic               ev_chain_end,
  output logic               ev_step_limit,
  output logic [STEP_W-1:0]  step_cnt
);

  localparam int KEY_W = VPN_W + PID_W;
  localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(FRAMES);

  // Fold the key bit by bit onto HASH_W positions: bit i lands on i mod HASH_W.
  function automatic logic [HASH_W-1:0] fold_key(input logic [VPN_W-1:0] v,
                                                 input logic [PID_W-1:0] p);
    logic [KEY_W-1:0]  k;
    logic [HASH_W-1:0] h;
    k = {p, v};
    h = '0;
    for (int i = 0; i < KEY_W; i++) h[i % HASH_W] = h[i % HASH_W] ^ k[i];
    return h;
  endfunction

  walk_state_e state_q, state_d;

  logic [VPN_W-1:0]   want_vpn_q;
  logic [PID_W-1:0]   want_pid_q;
  logic [FRAME_W-1:0] cur_idx_q;
  logic [VPN_W-1:0]   cur_vpn_q;
  logic [PID_W-1:0]   cur_pid_q;
  logic [PPN_W-1:0]   cur_ppn_q;
  logic               cur_lv_q;
  logic [FRAME_W-1:0] cur_link_q;
  logic [STEP_W-1:0]  step_q;
  logic               tag_match;

  assign tag_match = (cur_vpn_q == want_vpn_q) && (cur_pid_q == want_pid_q);

  assign req_ready      = (state_q == WS_IDLE);
  assign ev_accept      = req_ready && req_valid;
  assign ev_anchor_miss = (state_q == WS_ANCHOR) && !anc_rvalid;
  assign ev_row_hit     = (state_q == WS_COMPARE) && tag_match;
  assign ev_chain_end   = (state_q == WS_COMPARE) && !tag_match && !cur_lv_q;
  assign ev_step_limit  = (state_q == WS_COMPARE) && !tag_match && cur_lv_q &&
                          (step_q == STEP_MAX);

  assign anc_raddr = fold_key(req_vpn, req_pid);
  assign row_raddr = (state_q == WS_ANCHOR) ? anc_ridx : cur_link_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE:    if (req_valid) state_d = WS_ANCHOR;
      WS_ANCHOR:  state_d = anc_rvalid ? WS_ROW : WS_FAULT;
      WS_ROW:     state_d = WS_COMPARE;
      WS_COMPARE: begin
        if (ev_row_hit)                        state_d = WS_DONE;
        else if (ev_chain_end || ev_step_limit) state_d = WS_FAULT;
        else                                   state_d = WS_ROW;
      end
      WS_DONE, WS_FAULT: state_d = WS_IDLE;
      default:    state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= WS_IDLE;
      want_vpn_q <= '0;
      want_pid_q <= '0;
      cur_idx_q  <= '0;
      cur_vpn_q  <= '0;
      cur_pid_q  <= '0;
      cur_ppn_q  <= '0;
      cur_lv_q   <= 1'b0;
      cur_link_q <= '0;
      step_q     <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        WS_IDLE: if (req_valid) begin
          want_vpn_q <= req_vpn;
          want_pid_q <= req_pid;
          step_q     <= '0;
        end
        WS_ANCHOR: cur_idx_q <= anc_ridx;
        WS_ROW: begin
          cur_vpn_q  <= row_rvpn;
          cur_pid_q  <= row_rpid;
          cur_ppn_q  <= row_rppn;
          cur_lv_q   <= row_rlink_valid;
          cur_link_q <= row_rlink;
          step_q     <= step_q + 1'b1;
        end
        WS_COMPARE: if (state_d == WS_ROW) cur_idx_q <= cur_link_q;
        default: ;
      endcase
    end
  end

  assign resp_valid = (state_q == WS_DONE) || (state_q == WS_FAULT);
  assign resp_fault = (state_q == WS_FAULT);
  assign resp_frame = cur_idx_q;
  assign resp_ppn   = cur_ppn_q;
  assign step_cnt   = step_q;

endmodule

// File: rtl/ipt_walker.sv
module ipt_walker #(
  parameter int VPN_W  = 20,
  parameter int PID_W  = 8,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 6,
  parameter int FRAMES = 64,
  parameter int HASH_W = 6,
  localparam int VA_W    = VPN_W + OFF_W,
  localparam int FRAME_W = $clog2(FRAMES),
  localparam int STEP_W  = $clog2(FRAMES + 1),
  localparam int ROW_W   = VPN_W + PID_W + PPN_W + 1 + FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [PID_W-1:0]   req_pid,
  output logic               req_ready,
  output logic               resp_valid,
  output logic               resp_fault,
  output logic [FRAME_W-1:0] resp_frame,
  output logic [PPN_W-1:0]   resp_ppn,
  output logic [PPN_W+OFF_W-1:0] resp_paddr,
  input  logic               anc_we,
  input  logic [HASH_W-1:0]  anc_waddr,
  input  logic               anc_wvalid,
  input  logic [FRAME_W-1:0] anc_wrow,
  input  logic               row_we,
  input  logic [FRAME_W-1:0] row_waddr,
  input  logic [VPN_W-1:0]   row_wvpn,
  input  logic [PID_W-1:0]   row_wpid,
  input  logic [PPN_W-1:0]   row_wppn,
  input  logic               row_wlink_valid,
  input  logic [FRAME_W-1:0] row_wlink
);

  logic [VPN_W-1:0]   req_vpn;
  logic [OFF_W-1:0]   req_off;
  logic [OFF_W-1:0]   off_q;
  logic [HASH_W-1:0]  anc_raddr;
  logic               anc_rvalid;
  logic [FRAME_W-1:0] anc_ridx;
  logic [FRAME_W-1:0] row_raddr;
  logic [ROW_W-1:0]   row_rdata;
  logic [ROW_W-1:0]   row_wdata;
  logic [VPN_W-1:0]   row_rvpn;
  logic [PID_W-1:0]   row_rpid;
  logic [PPN_W-1:0]   row_rppn;
  logic               row_rlink_valid;
  logic [FRAME_W-1:0] row_rlink;

  // Internal events, named for the checker.
  logic               ev_accept;
  logic               ev_anchor_miss;
  logic               ev_row_hit;
  logic               ev_chain_end;
  logic               ev_step_limit;
  logic [STEP_W-1:0]  step_cnt;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];
  assign req_off = req_vaddr[OFF_W-1:0];

  // The offset bypasses the lookup and joins the result at the end.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         off_q <= '0;
    else if (ev_accept) off_q <= req_off;
  end

  assign row_wdata = {row_wvpn, row_wpid, row_wppn, row_wlink_valid, row_wlink};
  assign {row_rvpn, row_rpid, row_rppn, row_rlink_valid, row_rlink} = row_rdata;

  ipt_anchor_table #(.HASH_W(HASH_W), .IDX_W(FRAME_W)) u_anchor (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (anc_we),
    .waddr  (anc_waddr),
    .wvalid (anc_wvalid),
    .widx   (anc_wrow),
    .raddr  (anc_raddr),
    .rvalid (anc_rvalid),
    .ridx   (anc_ridx)
  );

  ipt_sram #(.WIDTH(ROW_W), .DEPTH(FRAMES)) u_rows (
    .clk   (clk),
    .we    (row_we),
    .waddr (row_waddr),
    .wdata (row_wdata),
    .raddr (row_raddr),
    .rdata (row_rdata)
  );

  ipt_walk_fsm #(
    .VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W),
    .FRAMES(FRAMES), .HASH_W(HASH_W)
  ) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_vpn         (req_vpn),
    .req_pid         (req_pid),
    .req_ready       (req_ready),
    .anc_raddr       (anc_raddr),
    .anc_rvalid      (anc_rvalid),
    .anc_ridx        (anc_ridx),
    .row_raddr       (row_raddr),
    .row_rvpn        (row_rvpn),
    .row_rpid        (row_rpid),
    .row_rppn        (row_rppn),
    .row_rlink_valid (row_rlink_valid),
    .row_rlink       (row_rlink),
    .resp_valid      (resp_valid),
    .resp_fault      (resp_fault),
    .resp_frame      (resp_frame),
    .resp_ppn        (resp_ppn),
    .ev_accept       (ev_accept),
    .ev_anchor_miss  (ev_anchor_miss),
    .ev_row_hit      (ev_row_hit),
    .ev_chain_end    (ev_chain_end),
    .ev_step_limit   (ev_step_limit),
    .step_cnt        (step_cnt)
  );

  assign resp_paddr = {resp_ppn, off_q};

endmodule

// File: rtl/ipt_walker_chk.sv
module ipt_walker_chk #(
  parameter int FRAMES = 64,
  parameter int STEP_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_fault,
  input logic              ev_anchor_miss,
  input logic              ev_row_hit,
  input logic              ev_chain_end,
  input logic              ev_step_limit,
  input logic [STEP_W-1:0] step_cnt
);

  AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);                                   // R9
  AST_READY_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> req_ready);                                     // R9
  AST_BUSY_DURING_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);                                    // R9
  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !resp_valid));     // R4
  AST_EMPTY_ANCHOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_anchor_miss |=> (resp_valid && resp_fault));                // R4
  AST_HIT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_row_hit |=> (resp_valid && !resp_fault));                   // R5
  AST_CHAIN_END_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chain_end |=> (resp_valid && resp_fault));                  // R7
  AST_STEP_LIMIT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step_limit |=> (resp_valid && resp_fault));                 // R8
  AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt <= STEP_W'(FRAMES));                                  // R8
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_anchor_miss, ev_row_hit, ev_chain_end, ev_step_limit})); // R6

endmodule

bind ipt_walker ipt_walker_chk #(.FRAMES(FRAMES), .STEP_W(STEP_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .resp_valid     (resp_valid),
  .resp_fault     (resp_fault),
  .ev_anchor_miss (ev_anchor_miss),
  .ev_row_hit     (ev_row_hit),
  .ev_chain_end   (ev_chain_end),
  .ev_step_limit  (ev_step_limit),
  .step_cnt       (step_cnt)
);

// File: tb/ipt_walker_bench.sv
module ipt_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_pid = '0;
  logic        req_ready, resp_valid, resp_fault;
  logic [5:0]  resp_frame, resp_ppn;
  logic [17:0] resp_paddr;
  logic        anc_we = 1'b0, anc_wvalid = 1'b0;
  logic [5:0]  anc_waddr = '0, anc_wrow = '0;
  logic        row_we = 1'b0, row_wlink_valid = 1'b0;
  logic [5:0]  row_waddr = '0, row_wppn = '0, row_wlink = '0;
  logic [19:0] row_wvpn = '0;
  logic [7:0]  row_wpid = '0;

  always #4 clk = ~clk;   // 125 MHz

  ipt_walker u_ipt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_pid(req_pid),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_fault(resp_fault),
    .resp_frame(resp_frame), .resp_ppn(resp_ppn), .resp_paddr(resp_paddr),
    .anc_we(anc_we), .anc_waddr(anc_waddr), .anc_wvalid(anc_wvalid), .anc_wrow(anc_wrow),
    .row_we(row_we), .row_waddr(row_waddr), .row_wvpn(row_wvpn), .row_wpid(row_wpid),
    .row_wppn(row_wppn), .row_wlink_valid(row_wlink_valid), .row_wlink(row_wlink)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // Behavioural picture of both tables.
  bit a_used [64];
  int a_head [64];
  int t_vpn [64], t_pid [64], t_ppn [64], t_next [64];
  bit t_more [64];

  // Model of the walk in progress.
  bit    m_busy = 0;
  int    m_age, m_lat, m_frame, m_ppn, m_off;
  bit    m_fault;
  string m_tag = "R5";
  string cur_tag = "R5";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // R3: XOR of 6-bit slices of {pid, vpn}, taken from the bottom up.
  function automatic int bucket(input int vpn, input int pid);
    int k = (pid << 20) | vpn;
    int h = 0;
    while (k != 0) begin
      h = h ^ (k & 63);
      k = k >> 6;
    end
    return h;
  endfunction

  task automatic predict(input int vpn, input int pid);
    int b = bucket(vpn, pid);
    int at;
    m_fault = 1;
    if (!a_used[b]) begin
      m_lat = 2;
      return;
    end
    at = a_head[b];
    for (int n = 1; n <= 64; n++) begin
      if (t_vpn[at] == vpn && t_pid[at] == pid) begin
        m_fault = 0; m_frame = at; m_ppn = t_ppn[at]; m_lat = 2 + 2 * n;
        return;
      end
      if (!t_more[at] || n == 64) begin
        m_lat = 2 + 2 * n;
        return;
      end
      at = t_next[at];
    end
  endtask

  // Compared on every clock, away from the edge.
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (m_busy) begin
        m_age++;
        chk(req_ready == 0, m_tag, "ready while walking", req_ready, 0);
        if (m_age == m_lat) begin
          chk(resp_valid == 1, m_tag, "resp_valid at latency", resp_valid, 1);
          chk(resp_fault == m_fault, m_tag, "resp_fault", resp_fault, m_fault);
          if (!m_fault) begin
            chk(resp_frame == m_frame, m_tag, "resp_frame", resp_frame, m_frame);
            chk(resp_ppn == m_ppn, m_tag, "resp_ppn", resp_ppn, m_ppn);
            chk(resp_paddr == ((m_ppn << 12) | m_off), "R2", "resp_paddr",
                resp_paddr, (m_ppn << 12) | m_off);
          end
          m_busy = 0;
        end else begin
          chk(resp_valid == 0, m_tag, "early resp_valid", resp_valid, 0);
        end
      end else begin
        chk(req_ready == 1, "R9", "ready when idle", req_ready, 1);
        chk(resp_valid == 0, "R9", "resp_valid when idle", resp_valid, 0);
        if (req_valid) begin
          predict(int'(req_vaddr[31:12]), int'(req_pid));
          m_off  = int'(req_vaddr[11:0]);
          m_tag  = cur_tag;
          m_age  = 0;
          m_busy = 1;
        end
      end
    end
  end

  task automatic put_anchor(input int b, input bit used, input int head);
    @(negedge clk);
    anc_we = 1; anc_waddr = 6'(b); anc_wvalid = used; anc_wrow = 6'(head);
    a_used[b] = used; a_head[b] = head;
    @(negedge clk);
    anc_we = 0;
  endtask

  task automatic put_row(input int r, input int vpn, input int pid, input int ppn,
                         input bit more, input int nxt);
    @(negedge clk);
    row_we = 1; row_waddr = 6'(r); row_wvpn = 20'(vpn); row_wpid = 8'(pid);
    row_wppn = 6'(ppn); row_wlink_valid = more; row_wlink = 6'(nxt);
    t_vpn[r] = vpn; t_pid[r] = pid; t_ppn[r] = ppn; t_more[r] = more; t_next[r] = nxt;
    @(negedge clk);
    row_we = 0;
  endtask

  task automatic lookup(input string tag, input int vpn, input int pid, input int off,
                        input bit noise);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 1; req_vaddr = {20'(vpn), 12'(off)}; req_pid = 8'(pid);
    @(negedge clk);
    req_valid = 0;
    if (noise) begin
      // R9: a request raised mid-walk must be ignored.
      @(negedge clk);
      @(negedge clk);
      req_valid = 1; req_vaddr = 32'hFFFF_F123; req_pid = 8'hEE;
      @(negedge clk);
      req_valid = 0;
    end
    do @(negedge clk); while (m_busy);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      a_used[i] = 0; a_head[i] = 0;
      t_vpn[i] = -1; t_pid[i] = -1; t_ppn[i] = 0; t_more[i] = 0; t_next[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #2;
    chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    chk(resp_valid == 0, "R1", "resp_valid after reset", resp_valid, 0);

    // R1 / R4: a table never written reports a fault at once.
    lookup("R4", 32'h00001, 0, 12'h000, 0);
    lookup("R1", 32'hABCDE, 8'h5A, 12'h7FF, 0);

    // Single-row bucket: vpn 0x12345, pid 0x07.
    put_row(3, 32'h12345, 8'h07, 6'h2A, 0, 0);
    put_anchor(bucket(32'h12345, 8'h07), 1, 3);
    lookup("R5", 32'h12345, 8'h07, 12'h000, 0);
    lookup("R2", 32'h12345, 8'h07, 12'hABC, 0);
    lookup("R3", 32'h12345, 8'h07, 12'hFFF, 0);

    // Three keys in bucket 1: (1,0x00), (5,0x01), (5,0x40).
    put_row(10, 1, 8'h00, 6'h11, 1, 20);
    put_row(20, 5, 8'h01, 6'h22, 1, 33);
    put_row(33, 5, 8'h40, 6'h33, 0, 0);
    put_anchor(1, 1, 10);
    lookup("R5", 1, 8'h00, 12'h010, 0);
    lookup("R6", 5, 8'h01, 12'h020, 0);
    lookup("R6", 5, 8'h40, 12'h030, 0);
    // R7: same bucket, no row owns this key.
    lookup("R7", 1, 8'h41, 12'h040, 0);
    // R4: same vpn, other pid, lands in an empty bucket.
    lookup("R4", 5, 8'h41, 12'h050, 0);

    // R9: noise during a three-row walk.
    lookup("R9", 5, 8'h40, 12'h060, 1);

    // R8: self-looping row in bucket of (0x300, 0).
    put_row(50, 32'h301, 8'h00, 6'h05, 1, 50);
    put_anchor(bucket(32'h300, 0), 1, 50);
    lookup("R8", 32'h300, 0, 12'h001, 0);
    // A loop through two rows that still holds the key on the second row.
    put_row(51, 32'h300, 8'h00, 6'h0C, 1, 50);
    put_row(50, 32'h301, 8'h00, 6'h05, 1, 51);
    lookup("R6", 32'h300, 0, 12'h002, 0);

    // Emptying a bucket turns its hit into a fault.
    put_anchor(bucket(32'h12345, 8'h07), 0, 3);
    lookup("R4", 32'h12345, 8'h07, 12'h003, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule